// File: doc/BRIEF.md
# Per-Frame DSI Short-Write Command Injector

This block holds a small list of one-parameter display command writes and turns them into MIPI DSI short packets. Software-side logic loads command/parameter byte pairs into a row of slots through a simple write strobe, then programs a control word that gives the number of bytes to send per frame and an enable bit.

Every time a frame-start strobe arrives while the block is enabled and idle, it walks the slots in order and emits each packet as four bytes on a byte stream with a valid/ready handshake. The header of each packet is assembled in hardware: a fixed data-type byte, the command byte, the parameter byte, and an 8-bit error-correcting code computed over the first three bytes. The same list is replayed at every later frame start until the enable bit is cleared.

Top module: `dsi_cmd_injector`

## Requirements
- R1: The first byte of every emitted packet is the data-type value 0x15 (short write carrying one parameter).
- R2: Each packet is sent as four bytes in the order data type, command byte, parameter byte, ECC byte; one byte moves per cycle in which txValid and txReady are both high, and txData and txValid hold steady while txReady is low.
- R3: The ECC byte has bits 7:6 at zero and bits 5:0 equal to the XOR, over every set bit i of the 24-bit header {parameter, command, 0x15} (bit 0 = data-type LSB), of code i, where codes 0..23 are 07,0B,0D,0E,13,15,16,19,1A,1C,23,25,26,29,2A,2C,31,32,34,38,1F,2F,37,3B hex; command 0x00 with parameter 0x00 gives ECC 0x19.
- R4: Slot loads fill slots 0 to 7 in order, and packets go out in slot order starting from slot 0.
- R5: A load while all eight slots are full sets the overflowErr output, which stays high until reset, and changes no slot.
- R6: The control word holds a byte count and an enable bit; with enable low a frame start produces no output, and a byte count above 32 is treated as 32.
- R7: While enabled, every frame start that finds the block idle replays the whole programmed byte sequence.
- R8: busy goes high with the first byte presented and falls after the last byte is accepted; a frame start arriving while busy is ignored.
- R9: A byte count of zero with enable set produces no output and leaves busy low.
- R10: A synchronous reset clears all slots, the slot counter, overflowErr and the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slotWrEn | input | 1 | Load the next free slot |
| slotCmd | input | 8 | Command byte for the slot load |
| slotParam | input | 8 | Parameter byte for the slot load |
| ctrlWrEn | input | 1 | Write the control word |
| ctrlLen | input | 6 | Bytes to send per frame |
| ctrlEnable | input | 1 | Enable per-frame transmission |
| frameStart | input | 1 | Frame-start strobe |
| txData | output | 8 | Output byte |
| txValid | output | 1 | Output byte is valid |
| txReady | input | 1 | Sink accepts the byte |
| busy | output | 1 | A sequence is in progress |
| overflowErr | output | 1 | Sticky slot-overflow flag |

## Verification
On every cycle the assertions watch the handshake holding data steady under back-pressure, the data-type byte at the start of each packet, the overflow flag refusing further loads and staying set, a zero byte count never raising busy, and reset clearing the state. Only the bench's scenarios can show that the ECC values are right for real headers, that slots come out in load order, that a mid-sequence frame start adds no extra bytes, that the sequence is replayed on the next frame, and that the byte count is clamped.

// File: rtl/dsi_inj_pkg.sv
package dsi_inj_pkg;
  localparam int MAX_SLOTS = 8;
  localparam int MAX_BYTES = 4 * MAX_SLOTS;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int CNT_W     = $clog2(MAX_SLOTS + 1);
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);
  localparam int HDR_BITS  = 24;

  localparam logic [7:0] SHORT_WR_1P = 8'h15;

  // Per-bit contribution to the header ECC, bit 0 first.
  localparam logic [5:0] ECC_CODE [HDR_BITS] = '{
    6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
    6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
    6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
  };

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] param;
  } slot_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic             active;
    logic [IDX_W-1:0] byteIdx;
  } txSel_t;

  function automatic logic [7:0] hdrEcc(input logic [HDR_BITS-1:0] hdr);
    logic [5:0] acc;
    acc = '0;
    for (int i = 0; i < HDR_BITS; i++) begin
      if (hdr[i]) acc = acc ^ ECC_CODE[i];
    end
    return {2'b00, acc};
  endfunction
endpackage

// File: rtl/dsi_inj_datapath.sv
module dsi_inj_datapath
  import dsi_inj_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       slotWrEn,
  input  logic [7:0] slotCmd,
  input  logic [7:0] slotParam,
  input  txSel_t     sel,
  output logic [7:0] txData,
  output logic       overflowErr
);
  slot_t            slots [MAX_SLOTS];
  logic [CNT_W-1:0] slotCnt;
  logic [31:0]      pktWord [MAX_SLOTS];
  logic             slotsFull;

  assign slotsFull = (slotCnt == CNT_W'(MAX_SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt     <= '0;
      overflowErr <= 1'b0;
      for (int s = 0; s < MAX_SLOTS; s++) slots[s] <= '0;
    end else if (slotWrEn) begin
      if (slotsFull) begin
        overflowErr <= 1'b1;
      end else begin
        slots[slotCnt[SLOT_W-1:0]] <= '{cmd: slotCmd, param: slotParam};
        slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  // One header builder per slot.
  for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_pkt
    logic [23:0] hdrLow;
    assign hdrLow     = {slots[g].param, slots[g].cmd, SHORT_WR_1P};
    assign pktWord[g] = {hdrEcc(hdrLow), hdrLow};
  end

  logic [SLOT_W-1:0] rdSlot;
  logic [1:0]        rdLane;
  assign rdSlot = sel.byteIdx[IDX_W-1:2];
  assign rdLane = sel.byteIdx[1:0];

  always_comb begin
    txData = 8'h00;
    if (sel.active) txData = pktWord[rdSlot][rdLane*8 +: 8];
  end

  a_r5_full_blocks_load: assert property (@(posedge clk) disable iff (rst)
    (slotWrEn && slotsFull) |=> (overflowErr && slotsFull));
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    overflowErr |=> overflowErr);
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (slotCnt == '0 && !overflowErr));
endmodule

// File: rtl/dsi_inj_ctrl.sv
module dsi_inj_ctrl
  import dsi_inj_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrlWrEn,
  input  logic [LEN_W-1:0] ctrlLen,
  input  logic             ctrlEnable,
  input  logic             frameStart,
  input  logic             txReady,
  output txSel_t           sel,
  output logic             txValid,
  output logic             busy
);
  typedef enum logic {ST_IDLE, ST_SEND} state_e;

  state_e           state;
  logic [LEN_W-1:0] lenReg;
  logic             enReg;
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [LEN_W-1:0] effLen;
  logic             kick;

  assign effLen = (lenReg > LEN_W'(MAX_BYTES)) ? LEN_W'(MAX_BYTES) : lenReg;
  assign kick   = (state == ST_IDLE) && frameStart && enReg && (effLen != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg <= '0;
      enReg  <= 1'b0;
    end else if (ctrlWrEn) begin
      lenReg <= ctrlLen;
      enReg  <= ctrlEnable;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (kick) begin
          state   <= ST_SEND;
          byteIdx <= '0;
          lastIdx <= IDX_W'(effLen - 1'b1);
        end
        ST_SEND: if (txReady) begin
          if (byteIdx == lastIdx) state <= ST_IDLE;
          else                    byteIdx <= byteIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txValid     = (state == ST_SEND);
  assign busy        = (state == ST_SEND);
  assign sel.active  = (state == ST_SEND);
  assign sel.byteIdx = byteIdx;

  a_r8_busy_holds_stalled: assert property (@(posedge clk) disable iff (rst)
    (busy && !txReady) |=> (busy && txValid));
  a_r9_zero_len_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && frameStart && effLen == '0) |=> !busy);
  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !enReg) |=> !busy);
endmodule

// File: rtl/dsi_cmd_injector.sv
module dsi_cmd_injector
  import dsi_inj_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       slotWrEn,
  input  logic [7:0] slotCmd,
  input  logic [7:0] slotParam,
  input  logic       ctrlWrEn,
  input  logic [5:0] ctrlLen,
  input  logic       ctrlEnable,
  input  logic       frameStart,
  output logic [7:0] txData,
  output logic       txValid,
  input  logic       txReady,
  output logic       busy,
  output logic       overflowErr
);
  txSel_t sel;

  dsi_inj_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctrlWrEn(ctrlWrEn), .ctrlLen(ctrlLen),
    .ctrlEnable(ctrlEnable), .frameStart(frameStart), .txReady(txReady),
    .sel(sel), .txValid(txValid), .busy(busy)
  );

  dsi_inj_datapath u_dp (
    .clk(clk), .rst(rst), .slotWrEn(slotWrEn), .slotCmd(slotCmd),
    .slotParam(slotParam), .sel(sel), .txData(txData),
    .overflowErr(overflowErr)
  );

  a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady && !slotWrEn) |=> (txValid && $stable(txData)));
  a_r1_type_byte_first: assert property (@(posedge clk) disable iff (rst)
    (txValid && sel.byteIdx[1:0] == 2'd0) |-> (txData == 8'h15));
  a_r8_busy_tracks_valid: assert property (@(posedge clk) disable iff (rst)
    busy |-> txValid);
endmodule

// File: tb/dsi_cmd_injector_tb_top.sv
module dsi_cmd_injector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slotWrEn = 1'b0;
  logic [7:0] slotCmd = '0, slotParam = '0;
  logic       ctrlWrEn = 1'b0;
  logic [5:0] ctrlLen = '0;
  logic       ctrlEnable = 1'b0;
  logic       frameStart = 1'b0;
  logic       txReady = 1'b0;
  logic [7:0] txData;
  logic       txValid, busy, overflowErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dsi_cmd_injector dut_i (
    .clk(clk), .rst(rst), .slotWrEn(slotWrEn), .slotCmd(slotCmd),
    .slotParam(slotParam), .ctrlWrEn(ctrlWrEn), .ctrlLen(ctrlLen),
    .ctrlEnable(ctrlEnable), .frameStart(frameStart), .txData(txData),
    .txValid(txValid), .txReady(txReady), .busy(busy),
    .overflowErr(overflowErr)
  );

  // Stimulus table: {command, parameter}; entry 0 exercises the all-zero header.
  localparam logic [15:0] CMD_TAB [8] = '{
    16'h0000, 16'h3A77, 16'h51FF, 16'h2901,
    16'hB6C3, 16'h1180, 16'h7E5A, 16'hE00F
  };
  localparam logic [5:0] CODE_TAB [24] = '{
    6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
    6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
    6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
  };

  // Reference ECC built column by column: each ECC bit is a parity.
  function automatic logic [7:0] eccRef(input logic [23:0] hdr);
    logic [7:0] e = '0;
    for (int k = 0; k < 6; k++) begin
      logic p = 1'b0;
      for (int i = 0; i < 24; i++) if (CODE_TAB[i][k]) p ^= hdr[i];
      e[k] = p;
    end
    return e;
  endfunction

  function automatic logic [7:0] expByte(input int slot, input int lane);
    logic [23:0] h;
    h = {CMD_TAB[slot][7:0], CMD_TAB[slot][15:8], 8'h15};
    case (lane)
      0: return h[7:0];
      1: return h[15:8];
      2: return h[23:16];
      default: return eccRef(h);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic loadSlot(input int idx);
    @(negedge clk);
    slotWrEn = 1'b1; slotCmd = CMD_TAB[idx][15:8]; slotParam = CMD_TAB[idx][7:0];
    @(negedge clk);
    slotWrEn = 1'b0;
  endtask

  task automatic writeCtrl(input int len, input bit en);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlLen = 6'(len); ctrlEnable = en;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic pulseFrame();
    @(negedge clk); frameStart = 1'b1;
    @(negedge clk); frameStart = 1'b0;
  endtask

  // Receive one byte, optionally after one stalled cycle.
  task automatic recvByte(input logic [7:0] exp, input string req, input bit stall);
    int guard = 0;
    logic [7:0] held;
    @(negedge clk);
    if (stall) begin
      txReady = 1'b0;
      held = txData;
      @(negedge clk);
      check(txValid && txData == held, "R2 stall hold", int'(txData), int'(held));
    end
    txReady = 1'b1;
    while (!txValid && guard < 50) begin @(negedge clk); guard++; end
    check(txValid && txData == exp, req, int'(txData), int'(exp));
    @(posedge clk);
  endtask

  task automatic recvSlots(input int n, input bit stall, input string req);
    for (int s = 0; s < n; s++)
      for (int l = 0; l < 4; l++) recvByte(expByte(s, l), req, stall && (l == 1));
    @(negedge clk); txReady = 1'b0;
  endtask

  task automatic expectQuiet(input int cycles, input string req);
    bit seen = 1'b0;
    txReady = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (txValid || busy) seen = 1'b1;
    end
    txReady = 1'b0;
    check(!seen, req, int'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !txValid && !overflowErr, "R10 reset state",
          int'({busy, txValid, overflowErr}), 0);

    // R9: zero count with enable produces nothing.
    writeCtrl(0, 1'b1);
    pulseFrame();
    expectQuiet(10, "R9 zero count quiet");

    // Table walk: load the first three entries and send them.
    for (int i = 0; i < 3; i++) loadSlot(i);
    writeCtrl(12, 1'b1);
    pulseFrame();
    check(busy, "R8 busy with first byte", int'(busy), 1);
    check(txData == 8'h15, "R1 type byte", int'(txData), 8'h15);
    recvByte(8'h15, "R1 slot0 type", 1'b0);
    recvByte(8'h00, "R2 slot0 cmd", 1'b0);
    recvByte(8'h00, "R2 slot0 param", 1'b0);
    recvByte(8'h19, "R3 zero header ECC", 1'b0);
    for (int s = 1; s < 3; s++)
      for (int l = 0; l < 4; l++) recvByte(expByte(s, l), "R4 slot order", 1'b0);
    @(negedge clk); txReady = 1'b0;
    check(!busy, "R8 busy falls after last byte", int'(busy), 0);

    // R7 replay with back-pressure, R8 frame start mid-sequence ignored.
    pulseFrame();
    for (int l = 0; l < 4; l++) recvByte(expByte(0, l), "R7 replay", 1'b1);
    @(negedge clk); txReady = 1'b0;
    pulseFrame();
    for (int s = 1; s < 3; s++)
      for (int l = 0; l < 4; l++) recvByte(expByte(s, l), "R3 ECC replay", 1'b0);
    expectQuiet(10, "R8 mid-send frame start ignored");

    // R6: enable low suppresses output.
    writeCtrl(12, 1'b0);
    pulseFrame();
    expectQuiet(10, "R6 disabled quiet");

    // R5: fill remaining slots, then overflow.
    for (int i = 3; i < 8; i++) loadSlot(i);
    check(!overflowErr, "R5 no error at eight", int'(overflowErr), 0);
    @(negedge clk);
    slotWrEn = 1'b1; slotCmd = 8'hAA; slotParam = 8'h55;
    @(negedge clk); slotWrEn = 1'b0;
    check(overflowErr, "R5 overflow flag", int'(overflowErr), 1);

    // R6 clamp: 40 bytes requested, 32 sent; slot 7 untouched (R5).
    writeCtrl(40, 1'b1);
    pulseFrame();
    recvSlots(8, 1'b1, "R5 R6 full list");
    expectQuiet(10, "R6 count clamped to 32");
    check(overflowErr, "R5 flag sticky", int'(overflowErr), 1);

    // R10: reset clears counter, flag and enable.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(!overflowErr && !busy, "R10 flag cleared", int'(overflowErr), 0);
    pulseFrame();
    expectQuiet(10, "R10 enable cleared");
    loadSlot(1);
    writeCtrl(4, 1'b1);
    pulseFrame();
    for (int l = 0; l < 4; l++) recvByte(expByte(1, l), "R10 counter restarts at slot 0", 1'b0);
    @(negedge clk); txReady = 1'b0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule